// File: doc/BRIEF.md
# Unsigned Multiply-Add with Split Wide Result

This execution unit forms `a * b + c` for unsigned operands of `DATA_W` bits (64 by default). The full double-width product is kept, and the addend is zero-extended and added to it without any shift. The double-width sum is returned as two single-width words. The less significant word goes to the primary destination register. The more significant word goes to an implicit second destination.

The unit also computes the register index of that implicit destination. In scalar mode it is the register after the primary destination. In vector mode one of two rules applies, chosen by a mode bit. The first rule mirrors the addend register index together with its scalar/vector flag. The second places the destination one maximum-vector-length past the primary destination. All index sums wrap modulo the register-file depth.

The pipeline has no handshake and a fixed latency of two cycles. Because the upper word can serve as the addend of the next operation, a chain of these operations multiplies a multi-word integer by one word, one limb per operation.

Top module: `umadd_split_unit`

## Requirements
- R1: `{out_hi, out_lo}` equals the full unsigned product `in_a * in_b` plus `in_c` zero-extended to 2*DATA_W bits, with no bits dropped.
- R2: `out_lo` is the less significant DATA_W bits of the sum. `out_rt_idx` repeats the `in_rt_idx` of the same operation.
- R3: The double-width sum never carries out. With all-ones operands, `out_hi` is all ones and `out_lo` is zero.
- R4: When `in_vec_mode`=0, `out_rs_idx` = (`in_rt_idx`+1) mod RF_DEPTH and `out_rs_vec`=0. With RF_DEPTH 128, rt index 127 gives 0.
- R5: When `in_vec_mode`=1 and `in_rs_is_rc`=1, `out_rs_idx` = `in_rc_idx` and `out_rs_vec` = `in_rc_vec`.
- R6: When `in_vec_mode`=1 and `in_rs_is_rc`=0, `out_rs_idx` = (`in_rt_idx`+`in_maxvl`) mod RF_DEPTH and `out_rs_vec` = `in_rt_vec`.
- R7: `out_valid` rises two rising clock edges after an edge that samples `in_valid`=1. Back-to-back operations come out on consecutive cycles.
- R8: Operands presented with `in_valid`=0 have no effect: every data and index output keeps its last value.
- R9: While `rst_n`=0, `out_valid`, `out_hi`, `out_lo`, `out_rt_idx`, `out_rs_idx` and `out_rs_vec` are all zero.
- R10: Feeding each `out_hi` back as the next `in_c` while stepping through the limbs of a multi-word integer yields that integer times `in_b`, limb by limb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | DATA_W | Multiplicand |
| in_b | input | DATA_W | Multiplier |
| in_c | input | DATA_W | Addend, zero-extended |
| in_rt_idx | input | IDX_W | Primary destination index |
| in_rt_vec | input | 1 | Primary destination is a vector |
| in_rc_idx | input | IDX_W | Addend register index |
| in_rc_vec | input | 1 | Addend register is a vector |
| in_vec_mode | input | 1 | Vector-extended encoding in use |
| in_rs_is_rc | input | 1 | Vector mode: high destination mirrors the addend register |
| in_maxvl | input | IDX_W | Maximum vector length |
| out_valid | output | 1 | Result present |
| out_lo | output | DATA_W | Low word of the sum |
| out_hi | output | DATA_W | High word of the sum |
| out_rt_idx | output | IDX_W | Destination index for out_lo |
| out_rs_idx | output | IDX_W | Destination index for out_hi |
| out_rs_vec | output | 1 | High destination is a vector |

## Verification
The hardest condition to reach is a sum whose upper word is saturated while the addend still carries into it. Only the all-ones corner does this, and the stimulus applies it both directly and at the last limb of an all-ones multi-word chain. The index wrap needs a primary index near the top of the register file. The stimulus uses index 127 with the +1 rule and index 100 with a maximum length of 40. The chain test closes the loop from `out_hi` back to `in_c` over three limbs and compares the result with a wide product formed separately.

// File: rtl/umadd_pkg.sv
package umadd_pkg;
  typedef enum logic [1:0] {
    RSSEL_NEXT   = 2'd0,
    RSSEL_MIRROR = 2'd1,
    RSSEL_STRIDE = 2'd2
  } rs_rule_e;

  function automatic rs_rule_e pick_rs_rule(input logic vec_mode, input logic rs_is_rc);
    if (!vec_mode)    return RSSEL_NEXT;
    else if (rs_is_rc) return RSSEL_MIRROR;
    else              return RSSEL_STRIDE;
  endfunction
endpackage

// File: rtl/umadd_dest_index.sv
module umadd_dest_index
  import umadd_pkg::*;
#(
  parameter int RF_DEPTH = 128,
  parameter int IDX_W    = $clog2(RF_DEPTH)
) (
  input  logic [IDX_W-1:0] rt_idx,
  input  logic             rt_vec,
  input  logic [IDX_W-1:0] rc_idx,
  input  logic             rc_vec,
  input  logic             vec_mode,
  input  logic             rs_is_rc,
  input  logic [IDX_W-1:0] maxvl,
  output logic [IDX_W-1:0] rs_idx,
  output logic             rs_vec
);
  localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(RF_DEPTH);

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] base,
                                                input logic [IDX_W-1:0] step);
    logic [IDX_W:0] tot;
    tot = ({1'b0, base} + {1'b0, step}) % DEPTH_V;
    return tot[IDX_W-1:0];
  endfunction

  rs_rule_e rule;

  always_comb begin
    rule = pick_rs_rule(vec_mode, rs_is_rc);
    unique case (rule)
      RSSEL_MIRROR: begin rs_idx = rc_idx; rs_vec = rc_vec; end
      RSSEL_STRIDE: begin rs_idx = wrap_add(rt_idx, maxvl); rs_vec = rt_vec; end
      default:      begin rs_idx = wrap_add(rt_idx, IDX_W'(1)); rs_vec = 1'b0; end
    endcase
  end
endmodule

// File: rtl/umadd_prod_stage.sv
module umadd_prod_stage #(
  parameter int DATA_W = 64,
  parameter int META_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [META_W-1:0] meta_i,
  output logic              vld_o,
  output logic [2*DATA_W-1:0] prod_o,
  output logic [DATA_W-1:0] c_o,
  output logic [META_W-1:0] meta_o
);
  localparam int PW = 2*DATA_W;

  function automatic logic [PW-1:0] wide_mul(input logic [DATA_W-1:0] x,
                                             input logic [DATA_W-1:0] y);
    return {{DATA_W{1'b0}}, x} * {{DATA_W{1'b0}}, y};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      prod_o <= '0;
      c_o    <= '0;
      meta_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        prod_o <= wide_mul(a_i, b_i);
        c_o    <= c_i;
        meta_o <= meta_i;
      end
    end
  end
endmodule

// File: rtl/umadd_sum_stage.sv
module umadd_sum_stage #(
  parameter int DATA_W = 64,
  parameter int META_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld_i,
  input  logic [2*DATA_W-1:0] prod_i,
  input  logic [DATA_W-1:0]   c_i,
  input  logic [META_W-1:0]   meta_i,
  output logic                vld_o,
  output logic [DATA_W-1:0]   hi_o,
  output logic [DATA_W-1:0]   lo_o,
  output logic [META_W-1:0]   meta_o
);
  localparam int PW = 2*DATA_W;

  function automatic logic [PW:0] add_zext(input logic [PW-1:0] p,
                                           input logic [DATA_W-1:0] c);
    return {1'b0, p} + {{(DATA_W+1){1'b0}}, c};
  endfunction

  logic [PW:0] sum_full;
  logic        sum_carry;

  assign sum_full  = add_zext(prod_i, c_i);
  assign sum_carry = sum_full[PW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      hi_o   <= '0;
      lo_o   <= '0;
      meta_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        hi_o   <= sum_full[PW-1:DATA_W];
        lo_o   <= sum_full[DATA_W-1:0];
        meta_o <= meta_i;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> !sum_carry); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(hi_o) && $stable(lo_o))); // R8
endmodule

// File: rtl/umadd_split_unit.sv
module umadd_split_unit #(
  parameter int DATA_W   = 64,
  parameter int RF_DEPTH = 128,
  parameter int IDX_W    = $clog2(RF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_c,
  input  logic [IDX_W-1:0]  in_rt_idx,
  input  logic              in_rt_vec,
  input  logic [IDX_W-1:0]  in_rc_idx,
  input  logic              in_rc_vec,
  input  logic              in_vec_mode,
  input  logic              in_rs_is_rc,
  input  logic [IDX_W-1:0]  in_maxvl,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_lo,
  output logic [DATA_W-1:0] out_hi,
  output logic [IDX_W-1:0]  out_rt_idx,
  output logic [IDX_W-1:0]  out_rs_idx,
  output logic              out_rs_vec
);
  localparam int META_W = 2*IDX_W + 1;

  logic [IDX_W-1:0]    rs_idx_c;
  logic                rs_vec_c;
  logic [META_W-1:0]   meta_in, s1_meta, s2_meta;
  logic                s1_valid;
  logic [2*DATA_W-1:0] s1_prod;
  logic [DATA_W-1:0]   s1_c;
  logic [IDX_W-1:0]    s1_rs_idx;
  logic                s1_rs_vec;

  umadd_dest_index #(.RF_DEPTH(RF_DEPTH), .IDX_W(IDX_W)) u_dest (
    .rt_idx(in_rt_idx), .rt_vec(in_rt_vec), .rc_idx(in_rc_idx), .rc_vec(in_rc_vec),
    .vec_mode(in_vec_mode), .rs_is_rc(in_rs_is_rc), .maxvl(in_maxvl),
    .rs_idx(rs_idx_c), .rs_vec(rs_vec_c)
  );

  assign meta_in = {in_rt_idx, rs_idx_c, rs_vec_c};

  umadd_prod_stage #(.DATA_W(DATA_W), .META_W(META_W)) u_prod (
    .clk(clk), .rst_n(rst_n), .vld_i(in_valid), .a_i(in_a), .b_i(in_b), .c_i(in_c),
    .meta_i(meta_in), .vld_o(s1_valid), .prod_o(s1_prod), .c_o(s1_c), .meta_o(s1_meta)
  );

  umadd_sum_stage #(.DATA_W(DATA_W), .META_W(META_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .vld_i(s1_valid), .prod_i(s1_prod), .c_i(s1_c),
    .meta_i(s1_meta), .vld_o(out_valid), .hi_o(out_hi), .lo_o(out_lo), .meta_o(s2_meta)
  );

  assign s1_rs_idx  = s1_meta[IDX_W:1];
  assign s1_rs_vec  = s1_meta[0];
  assign out_rt_idx = s2_meta[META_W-1:IDX_W+1];
  assign out_rs_idx = s2_meta[IDX_W:1];
  assign out_rs_vec = s2_meta[0];

  AST_VALID_S1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid); // R7
  AST_VALID_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid); // R7
  AST_SCALAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_vec_mode && (in_rt_idx != IDX_W'(RF_DEPTH-1))) |=>
      (s1_rs_idx == $past(in_rt_idx) + IDX_W'(1)) && !s1_rs_vec); // R4
  AST_MIRROR_RC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_vec_mode && in_rs_is_rc) |=>
      (s1_rs_idx == $past(in_rc_idx)) && (s1_rs_vec == $past(in_rc_vec))); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_hi == '0 && out_lo == '0)); // R9
endmodule

// File: tb/test_umadd_split_unit.sv
`timescale 1ns/1ps
module test_umadd_split_unit;
  localparam int W = 64;
  localparam int IW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic [IW-1:0] in_rt_idx = '0, in_rc_idx = '0, in_maxvl = '0;
  logic in_rt_vec = 1'b0, in_rc_vec = 1'b0, in_vec_mode = 1'b0, in_rs_is_rc = 1'b0;
  logic out_valid, out_rs_vec;
  logic [W-1:0] out_lo, out_hi;
  logic [IW-1:0] out_rt_idx, out_rs_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  umadd_split_unit i_umadd_split_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .in_rt_idx(in_rt_idx), .in_rt_vec(in_rt_vec), .in_rc_idx(in_rc_idx), .in_rc_vec(in_rc_vec),
    .in_vec_mode(in_vec_mode), .in_rs_is_rc(in_rs_is_rc), .in_maxvl(in_maxvl),
    .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi), .out_rt_idx(out_rt_idx),
    .out_rs_idx(out_rs_idx), .out_rs_vec(out_rs_vec)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
    end
  endtask

  // Reference built from 32-bit partial products.
  function automatic logic [127:0] ref_madd(input logic [63:0] a, input logic [63:0] b,
                                            input logic [63:0] c);
    logic [127:0] acc;
    acc = {64'd0, c};
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++)
        acc = acc + ({96'd0, a[32*i +: 32]} * {96'd0, b[32*j +: 32]} << (32*(i+j)));
    return acc;
  endfunction

  task automatic drive(input logic [63:0] a, b, c);
    in_valid = 1'b1; in_a = a; in_b = b; in_c = c;
  endtask

  task automatic run_op(input string tag, input logic [63:0] a, b, c);
    logic [127:0] e;
    e = ref_madd(a, b, c);
    @(negedge clk); drive(a, b, c);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk({tag, " valid R7"}, 256'(out_valid), 256'(1));
    chk({tag, " sum R1"}, 256'({out_hi, out_lo}), 256'(e));
    chk({tag, " lo R2"}, 256'(out_lo), 256'(e[63:0]));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("reset valid R9", 256'(out_valid), 256'(0));
    chk("reset data R9", 256'({out_hi, out_lo, out_rt_idx, out_rs_idx, out_rs_vec}), 256'(0));
  endtask

  task automatic t_patterns;
    in_vec_mode = 1'b0; in_rt_idx = 7'd5;
    run_op("small", 64'd3, 64'd7, 64'd11);
    run_op("zero b", 64'hDEAD_BEEF_0000_1234, 64'd0, 64'h8000_0000_0000_0001);
    run_op("mid", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'hFFFF_0000_FFFF_0000);
    chk("rt idx R2", 256'(out_rt_idx), 256'(5));
  endtask

  task automatic t_all_ones;
    run_op("ones", '1, '1, '1);
    chk("ones hi R3", 256'(out_hi), 256'({64{1'b1}}));
    chk("ones lo R3", 256'(out_lo), 256'(0));
  endtask

  task automatic t_scalar_wrap;
    in_vec_mode = 1'b0; in_rt_vec = 1'b1; in_rt_idx = 7'd127;
    run_op("scalar", 64'd1, 64'd1, 64'd0);
    chk("scalar wrap R4", 256'(out_rs_idx), 256'(0));
    chk("scalar vec R4", 256'(out_rs_vec), 256'(0));
    in_rt_idx = 7'd20;
    run_op("scalar2", 64'd2, 64'd2, 64'd0);
    chk("scalar next R4", 256'(out_rs_idx), 256'(21));
  endtask

  task automatic t_mirror;
    in_vec_mode = 1'b1; in_rs_is_rc = 1'b1; in_rt_idx = 7'd10; in_rc_idx = 7'd77; in_rc_vec = 1'b1;
    in_rt_vec = 1'b0;
    run_op("mirror", 64'd5, 64'd6, 64'd7);
    chk("mirror idx R5", 256'(out_rs_idx), 256'(77));
    chk("mirror vec R5", 256'(out_rs_vec), 256'(1));
    in_rc_vec = 1'b0; in_rc_idx = 7'd3;
    run_op("mirror2", 64'd5, 64'd6, 64'd7);
    chk("mirror scalar R5", 256'({out_rs_idx, out_rs_vec}), 256'({7'd3, 1'b0}));
  endtask

  task automatic t_stride;
    in_vec_mode = 1'b1; in_rs_is_rc = 1'b0; in_rt_idx = 7'd100; in_maxvl = 7'd40; in_rt_vec = 1'b1;
    run_op("stride", 64'd9, 64'd9, 64'd9);
    chk("stride wrap R6", 256'(out_rs_idx), 256'(12));
    chk("stride vec R6", 256'(out_rs_vec), 256'(1));
    in_rt_idx = 7'd8; in_maxvl = 7'd16; in_rt_vec = 1'b0;
    run_op("stride2", 64'd9, 64'd9, 64'd9);
    chk("stride add R6", 256'({out_rs_idx, out_rs_vec}), 256'({7'd24, 1'b0}));
  endtask

  task automatic t_back_to_back;
    in_vec_mode = 1'b0;
    @(negedge clk); drive(64'd100, 64'd200, 64'd1); in_rt_idx = 7'd1;
    @(negedge clk); drive('1, 64'd2, 64'd3); in_rt_idx = 7'd2;
    @(negedge clk); in_valid = 1'b0;
    chk("b2b first R7", 256'({out_valid, out_hi, out_lo, out_rt_idx}),
        256'({1'b1, ref_madd(64'd100, 64'd200, 64'd1), 7'd1}));
    @(negedge clk);
    chk("b2b second R7", 256'({out_valid, out_hi, out_lo, out_rt_idx}),
        256'({1'b1, ref_madd('1, 64'd2, 64'd3), 7'd2}));
    @(negedge clk);
    chk("b2b idle R7", 256'(out_valid), 256'(0));
  endtask

  task automatic t_ignore;
    logic [127:0] held;
    logic [IW-1:0] hrs;
    held = {out_hi, out_lo}; hrs = out_rs_idx;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_a = 64'hAAAA_5555_AAAA_5555 + 64'(k); in_b = '1; in_c = '1;
      in_rt_idx = 7'(k * 31); in_vec_mode = 1'b0;
    end
    @(negedge clk); @(negedge clk);
    chk("ignore valid R8", 256'(out_valid), 256'(0));
    chk("ignore data R8", 256'({out_hi, out_lo}), 256'(held));
    chk("ignore idx R8", 256'(out_rs_idx), 256'(hrs));
  endtask

  task automatic t_chain(input logic [191:0] big, input logic [63:0] mul, input string tag);
    logic [255:0] got, want;
    logic [63:0] carry;
    carry = '0; got = '0;
    want = {64'd0, big} * {192'd0, mul};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); drive(big[64*i +: 64], mul, carry);
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      got[64*i +: 64] = out_lo;
      carry = out_hi;
    end
    got[255:192] = carry;
    chk({tag, " chain R10"}, got, want);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_patterns();
        t_all_ones();
        t_scalar_wrap();
        t_mirror();
        t_stride();
        t_back_to_back();
        t_ignore();
        t_chain({64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F0F_F0F0_1234_4321},
                64'hC0FF_EE00_1234_5678, "mixed");
        t_chain({192{1'b1}}, {64{1'b1}}, "ones R3");
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R7 act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule